// File: doc/BRIEF.md
# CAN Transmit Dominant Guard and Clear-to-Send Status

This block sits on the transmit path of a CAN transceiver. A watchdog counts how long the transmit-data input has held the bus dominant. If that run goes past a configured limit, the block withdraws the transmitter enable so the bus falls back to recessive. The enable stays withdrawn until the transmit-data input is seen recessive again. The next dominant level then starts a fresh count. Outside active mode the watchdog is held cleared and the transmitter is kept off.

The same watchdog feeds a combined readiness output for the host controller. That output is high only when all of these hold: the transceiver is active, start-up has finished, neither supply flag reports an undervoltage, and no dominant timeout is in force. The limit is a parameter in clock cycles. It must be set longer than the longest legal dominant run at the slowest supported bit rate of 15 kbit/s. The block has no data stream. Every pin is a plain level, so no valid/ready handshake or back-pressure applies.

Top module: `txguard_top`

## Requirements
- R1: While active_i is 1 and txd_i is 0 (dominant), the watchdog counts consecutive sampled clock edges. After DOM_LIMIT consecutive dominant samples, tx_en_o is 0 following that edge. After DOM_LIMIT-1 such samples it is still 1.
- R2: Once tripped, tx_en_o stays 0 for as long as txd_i stays 0. The first clock edge that samples txd_i at 1 (recessive) clears the trip, and tx_en_o is 1 after that edge.
- R3: A dominant run that follows a recessive sample is counted from zero. It again needs the full DOM_LIMIT samples to trip.
- R4: While active_i is 0, tx_en_o is 0 in the same cycle, and the watchdog count and trip are cleared at the next edge.
- R5: With DOM_LIMIT above 17 bit times at 15 kbit/s (17 x 64 cycles at the bench clock scaling), a dominant run of 17 bit times does not drop tx_en_o.
- R6: cts_o is 1 exactly when active_i is 1, startup_done_i is 1, uv_io_i is 0, uv_buf_i is 0 and no timeout is in force. In every other case it is 0.
- R7: cts_o is 0 while startup_done_i is 0, even when the transmitter is enabled.
- R8: cts_o is 0 whenever uv_io_i or uv_buf_i is 1.
- R9: cts_o is 0 for the whole time a dominant timeout is in force.
- R10: While rst_n is 0, and just after it is released with active_i at 0, both tx_en_o and cts_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| active_i | input | 1 | Transceiver is in active (normal) mode |
| startup_done_i | input | 1 | Transceiver start-up has completed |
| uv_io_i | input | 1 | Undervoltage flag for the I/O supply |
| uv_buf_i | input | 1 | Undervoltage flag for the buffer supply |
| txd_i | input | 1 | Transmit data, 0 dominant, 1 recessive |
| tx_en_o | output | 1 | Transmitter enable |
| cts_o | output | 1 | Clear-to-send status to the host |

## Verification
The bench targets the exact trip boundary. A run of DOM_LIMIT-1 dominant samples must leave the driver on, and one more sample must cut it. An off-by-one counter would cut one cycle early or one cycle late. After a trip the bench holds the input dominant for a long stretch and then gives a single recessive cycle. A design that re-armed on its own would re-enable while still dominant, and one that kept a stale count would trip early on the next run. Dropping active mode in the middle of a run, and holding a full 17 bit times of dominant at the lowest bit rate, expose designs that keep counting outside active mode or use too short a limit. Each readiness condition is toggled on its own, so a status term that is missing shows up as cts_o going high when it should not.

// File: rtl/txg_pkg.sv
package txg_pkg;

  // Watchdog phase of the transmit guard
  typedef enum logic [1:0] {
    TG_IDLE  = 2'd0,  // not in active mode, cleared
    TG_READY = 2'd1,  // active, transmit recessive
    TG_DOM   = 2'd2,  // active, counting a dominant run
    TG_CUT   = 2'd3   // active, driver withdrawn after timeout
  } tg_state_e;

  function automatic int unsigned tg_cnt_width(int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/txg_dom_timer.sv
module txg_dom_timer
  import txg_pkg::*;
#(
  parameter int unsigned LIMIT = 1200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic txd_i,
  output logic tripped_o
);
  localparam int unsigned CW = tg_cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  tg_state_e      st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!active_i) begin
      st_d  = TG_IDLE;
      cnt_d = '0;
    end else if (txd_i) begin
      st_d  = TG_READY;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        TG_CUT: begin
          st_d  = TG_CUT;
          cnt_d = '0;
        end
        default: begin
          if (cnt_q == LAST) begin
            st_d  = TG_CUT;
            cnt_d = '0;
          end else begin
            st_d  = TG_DOM;
            cnt_d = cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TG_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign tripped_o = (st_q == TG_CUT);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R1
  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !txd_i && tripped_o) |=> tripped_o); // R2
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && txd_i) |=> (!tripped_o && cnt_q == '0)); // R3
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (st_q == TG_IDLE && cnt_q == '0)); // R4

endmodule

// File: rtl/txg_status.sv
module txg_status (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic startup_done_i,
  input  logic uv_io_i,
  input  logic uv_buf_i,
  input  logic tripped_i,
  output logic tx_en_o,
  output logic cts_o
);
  logic supply_ok;
  logic path_ok;

  assign supply_ok = !(uv_io_i || uv_buf_i);
  assign path_ok   = active_i && !tripped_i;
  assign tx_en_o   = path_ok;
  assign cts_o     = path_ok && startup_done_i && supply_ok;

  AST_EN_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |-> !tx_en_o); // R4
  AST_CTS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    cts_o |-> tx_en_o); // R6
  AST_CTS_STARTUP: assert property (@(posedge clk) disable iff (!rst_n)
    !startup_done_i |-> !cts_o); // R7
  AST_CTS_UV: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_io_i || uv_buf_i) |-> !cts_o); // R8
  AST_CTS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    tripped_i |-> !cts_o); // R9

endmodule

// File: rtl/txguard_top.sv
module txguard_top #(
  parameter int unsigned DOM_LIMIT = 1200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic startup_done_i,
  input  logic uv_io_i,
  input  logic uv_buf_i,
  input  logic txd_i,
  output logic tx_en_o,
  output logic cts_o
);
  logic tripped;

  txg_dom_timer #(.LIMIT(DOM_LIMIT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .active_i  (active_i),
    .txd_i     (txd_i),
    .tripped_o (tripped)
  );

  txg_status u_status (
    .clk            (clk),
    .rst_n          (rst_n),
    .active_i       (active_i),
    .startup_done_i (startup_done_i),
    .uv_io_i        (uv_io_i),
    .uv_buf_i       (uv_buf_i),
    .tripped_i      (tripped),
    .tx_en_o        (tx_en_o),
    .cts_o          (cts_o)
  );

  AST_RECESSIVE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && txd_i) |=> (!active_i || tx_en_o)); // R2

endmodule

// File: tb/txguard_top_bench.sv
`timescale 1ns/1ps
module txguard_top_bench;
  localparam int LIM     = 1200;
  localparam int BIT_CYC = 64;   // one bit time at 15 kbit/s, scaled clock

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic active = 1'b0, sdone = 1'b0, uvio = 1'b0, uvbuf = 1'b0, txd = 1'b1;
  logic tx_en, cts;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int run = 0;
  bit mtrip = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  txguard_top #(.DOM_LIMIT(LIM)) u_txguard_top (
    .clk(clk), .rst_n(rst_n), .active_i(active), .startup_done_i(sdone),
    .uv_io_i(uvio), .uv_buf_i(uvbuf), .txd_i(txd),
    .tx_en_o(tx_en), .cts_o(cts)
  );

  // behavioural reference: length of the current dominant run and a trip flag
  always @(posedge clk) begin
    cycles++;
    if (!rst_n || !active || txd) begin
      run = 0;
      mtrip = 1'b0;
    end else if (!mtrip) begin
      run++;
      if (run >= LIM) mtrip = 1'b1;
    end
  end

  function automatic bit exp_en();
    return active && !mtrip;
  endfunction
  function automatic bit exp_cts();
    return active && !mtrip && sdone && !uvio && !uvbuf;
  endfunction

  task automatic chk(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(tx_en, exp_en(), "R1 tx_en vs model");
      chk(cts, exp_cts(), "R6 cts vs model");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    cyc(3);
    chk(tx_en, 1'b0, "R10 tx_en in reset");
    chk(cts, 1'b0, "R10 cts in reset");
    @(negedge clk); rst_n = 1'b1;
    cyc(2);
    chk(tx_en, 1'b0, "R10 tx_en after reset");
    chk(cts, 1'b0, "R10 cts after reset");

    @(negedge clk); active = 1'b1; txd = 1'b1;
    cyc(2);
    chk(tx_en, 1'b1, "R6 enabled");
    chk(cts, 1'b0, "R7 cts low before startup done");
    @(negedge clk); sdone = 1'b1;
    cyc(1);
    chk(cts, 1'b1, "R6 all conditions met");
    @(negedge clk); uvio = 1'b1;
    cyc(1);
    chk(cts, 1'b0, "R8 io undervoltage");
    @(negedge clk); uvio = 1'b0; uvbuf = 1'b1;
    cyc(1);
    chk(cts, 1'b0, "R8 buffer undervoltage");
    chk(tx_en, 1'b1, "R8 driver unaffected by undervoltage");
    @(negedge clk); uvbuf = 1'b0;
    cyc(1);

    // 17 dominant bits at the lowest bit rate
    @(negedge clk); txd = 1'b0;
    cyc(17 * BIT_CYC);
    chk(tx_en, 1'b1, "R5 17 dominant bits keep driver");
    @(negedge clk); txd = 1'b1;
    cyc(2);

    // exact trip boundary
    @(negedge clk); txd = 1'b0;
    cyc(LIM - 1);
    chk(tx_en, 1'b1, "R1 limit minus one");
    cyc(1);
    chk(tx_en, 1'b0, "R1 trip at limit");
    chk(cts, 1'b0, "R9 cts low on timeout");
    cyc(300);
    chk(tx_en, 1'b0, "R2 stays cut while dominant");
    @(negedge clk); txd = 1'b1;
    cyc(1);
    chk(tx_en, 1'b1, "R2 recessive re-arms");
    chk(cts, 1'b1, "R6 cts back after re-arm");

    // fresh run after re-arm
    @(negedge clk); txd = 1'b0;
    cyc(LIM - 1);
    chk(tx_en, 1'b1, "R3 fresh count");
    cyc(1);
    chk(tx_en, 1'b0, "R3 fresh run trips at limit");
    @(negedge clk); txd = 1'b1;
    cyc(1);

    // leaving active mode mid-run clears the count
    @(negedge clk); txd = 1'b0;
    cyc(LIM / 2);
    @(negedge clk); active = 1'b0;
    #2;
    chk(tx_en, 1'b0, "R4 inactive cuts driver at once");
    cyc(3);
    @(negedge clk); active = 1'b1;
    cyc(LIM - 1);
    chk(tx_en, 1'b1, "R4 count cleared while inactive");
    cyc(1);
    chk(tx_en, 1'b0, "R4 full limit after return");
    @(negedge clk); txd = 1'b1;
    cyc(1);

    // frame-like traffic: alternating runs of 1..5 bits
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); txd = ~txd;
      cyc(((i % 5) + 1) * BIT_CYC);
    end
    chk(tx_en, 1'b1, "R5 legal traffic never trips");
    cyc(2);
    finish_run();
  end
endmodule